// File: doc/BRIEF.md
# Eight-bit serial control-word receiver

This block receives 8-bit control words over a three-wire, write-only serial link: a serial clock, a serial data line and an active-low frame enable. The block runs on a much faster system clock. It brings all three wires into the system clock domain through synchronizer chains. It finds rising edges of the serial clock by comparing each synchronized value with its value one cycle earlier. While enable is low, it shifts the data bit in on each rising edge.

A frame carries the most significant bit first. The word is committed on the eighth rising edge of the frame, not when enable returns high. At that point the parallel output register loads the word and a valid strobe is high for one system clock. If a frame ends early, nothing is written. Clock edges after the eighth in the same frame are ignored. Each new frame starts from a cleared state when enable falls. The word is not decoded into gain or mute settings here; a downstream block does that.

Top module: `ctl_word_rx`

## Requirements
- R1: While reset is asserted and after it is released, `word_o` is 0 and `word_valid_o` is 0.
- R2: Bits are taken most significant bit first: the data value at the first rising edge of a frame lands in `word_o[7]`, and the value at the eighth lands in `word_o[0]`.
- R3: Serial clock rising edges seen while enable is high shift nothing and produce no strobe; `word_o` keeps its value.
- R4: With the default two-stage synchronizer, `word_valid_o` is high in the third system clock cycle after the eighth rising serial clock edge reaches the input pin, and low in the two cycles before it.
- R5: `word_valid_o` is high for exactly one system clock per completed frame.
- R6: A frame in which enable returns high after fewer than 8 rising edges gives no strobe, and `word_o` keeps its previous value.
- R7: Rising edges after the eighth in the same frame are ignored: there is no second strobe, and `word_o` holds the first eight bits.
- R8: A falling edge of enable clears the bit count and the shift register, so bits left over from an aborted frame never appear in the next word.
- R9: A serial clock rising edge that reaches the synchronizer outputs in the same system clock as the enable falling edge is taken as the first bit of the new frame.
- R10: `word_o` changes only in the cycle in which `word_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Serial clock; data is sampled on its rising edge |
| sdata_in | input | 1 | Serial data, most significant bit first |
| sen_n_in | input | 1 | Active-low frame enable |
| word_o | output | 8 | Last committed control word |
| word_valid_o | output | 1 | One-cycle strobe when `word_o` is loaded |

## Verification
Two things can fall in the same synchronized cycle: the frame restart caused by the falling edge of enable, and the shift of a bit on a rising serial clock edge. The bench provokes this by changing enable and the serial clock together at one input instant. Both wires pass through chains of equal length, so the two events reach the logic together. The result is correct only if that edge becomes bit 7 of the new word and the seven bits that follow complete the frame with one strobe. The bench also sweeps all 256 word values. The commit cycle of each frame is checked against the fixed pin-to-strobe latency.

// File: rtl/ctl_word_rx.sv
module ctl_word_rx #(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_in,
  input  logic              sdata_in,
  input  logic              sen_n_in,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

  logic [SYNC_STAGES-1:0] sclk_sy, data_sy, en_sy;
  logic                   sclk_d, en_d;
  logic [CNT_W-1:0]       cnt;
  logic [WORD_W-1:0]      shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sy <= '0;
      data_sy <= '0;
      en_sy   <= '1;
      sclk_d  <= 1'b0;
      en_d    <= 1'b1;
    end else begin
      sclk_sy <= {sclk_sy[SYNC_STAGES-2:0], sclk_in};
      data_sy <= {data_sy[SYNC_STAGES-2:0], sdata_in};
      en_sy   <= {en_sy[SYNC_STAGES-2:0], sen_n_in};
      sclk_d  <= sclk_sy[SYNC_STAGES-1];
      en_d    <= en_sy[SYNC_STAGES-1];
    end
  end

  wire sclk_s  = sclk_sy[SYNC_STAGES-1];
  wire data_s  = data_sy[SYNC_STAGES-1];
  wire en_low  = ~en_sy[SYNC_STAGES-1];
  wire rise    = sclk_s & ~sclk_d;
  wire en_fall = en_low & en_d;
  wire take    = en_low & rise & (cnt < CNT_FULL);
  wire [WORD_W-1:0] shifted = {shreg[WORD_W-2:0], data_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      shreg <= '0;
    end else if (en_fall) begin
      cnt   <= rise ? CNT_W'(1) : '0;
      shreg <= rise ? WORD_W'(data_s) : '0;
    end else if (take) begin
      cnt   <= cnt + CNT_W'(1);
      shreg <= shifted;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_o       <= '0;
      word_valid_o <= 1'b0;
    end else begin
      word_valid_o <= 1'b0;
      if (!en_fall && take && cnt == CNT_LAST) begin
        word_o       <= shifted;
        word_valid_o <= 1'b1;
      end
    end
  end

  p_single_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |=> !word_valid_o);

  p_word_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid_o |-> $stable(word_o));

  p_ignore_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_low |=> !word_valid_o);

  p_count_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_FULL);

  p_commit_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> cnt == CNT_FULL);

  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en_fall && !rise |=> cnt == '0);

endmodule

// File: tb/ctl_word_rx_tb.sv
module ctl_word_rx_tb;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk_in = 1'b0, sdata_in = 1'b0, sen_n_in = 1'b1;
  logic [7:0] word_o;
  logic word_valid_o;

  int checks = 0, failures = 0, pulses = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ctl_word_rx u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .sdata_in(sdata_in),
    .sen_n_in(sen_n_in), .word_o(word_o), .word_valid_o(word_valid_o)
  );

  always @(negedge clk) if (word_valid_o) pulses++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // nbits rising edges; bits past the eighth carry inverted data
  task automatic frame(input logic [7:0] w, input int nbits, input bit coincide);
    int p0;
    logic [7:0] prev;
    p0 = pulses;
    prev = word_o;
    if (coincide) begin
      sdata_in = w[7];
      sen_n_in = 1'b0;
      sclk_in  = 1'b1;
      wn(HALF);
    end else begin
      sen_n_in = 1'b0;
      wn(HALF);
    end
    for (int i = coincide ? 1 : 0; i < nbits; i++) begin
      sclk_in  = 1'b0;
      sdata_in = (i < 8) ? w[7-i] : ~w[(i-8)%8];
      wn(HALF);
      sclk_in = 1'b1;
      if (i == 7) begin
        wn(2);
        chk(word_valid_o == 1'b0, "R4 early strobe", word_valid_o, 0);
        wn(1);
        chk(word_valid_o == 1'b1, "R4 strobe cycle", word_valid_o, 1);
        chk(word_o == w, coincide ? "R9 word" : "R2 word", word_o, w);
        wn(1);
        chk(word_valid_o == 1'b0, "R5 strobe width", word_valid_o, 0);
        wn(HALF - 4);
      end else begin
        wn(HALF);
      end
    end
    sclk_in = 1'b0;
    wn(HALF);
    sen_n_in = 1'b1;
    wn(HALF + 4);
    if (nbits >= 8) begin
      chk(pulses - p0 == 1, nbits > 8 ? "R7 strobe count" : "R5 strobe count", pulses - p0, 1);
      if (nbits > 8) chk(word_o == w, "R7 word kept", word_o, w);
    end else begin
      chk(pulses - p0 == 0, "R6 no strobe", pulses - p0, 0);
      chk(word_o == prev, "R6 word kept", word_o, prev);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    wn(3);
    chk(word_o == 8'h00 && word_valid_o == 1'b0, "R1 in reset", {word_valid_o, word_o}, 0);
    rst_n = 1'b1;
    wn(5);
    chk(word_o == 8'h00 && word_valid_o == 1'b0, "R1 after reset", {word_valid_o, word_o}, 0);

    for (int v = 0; v < 256; v++) frame(8'(v), 8, 1'b0);

    begin
      int p0;
      logic [7:0] prev;
      p0 = pulses;
      prev = word_o;
      for (int k = 0; k < 12; k++) begin
        sdata_in = k[0];
        sclk_in = 1'b1; wn(HALF);
        sclk_in = 1'b0; wn(HALF);
      end
      wn(4);
      chk(pulses == p0, "R3 no strobe with enable high", pulses - p0, 0);
      chk(word_o == prev, "R3 word kept", word_o, prev);
    end

    for (int n = 0; n < 8; n++) frame(8'hA5 ^ 8'(n * 37), n, 1'b0);
    for (int n = 9; n <= 12; n++) frame(8'h3C + 8'(n), n, 1'b0);

    frame(8'hFF, 5, 1'b0);
    frame(8'h01, 8, 1'b0);
    chk(word_o == 8'h01, "R8 leftover cleared", word_o, 8'h01);

    frame(8'hFF, 3, 1'b0);
    frame(8'h96, 8, 1'b1);
    frame(8'h5A, 8, 1'b1);
    chk(word_o == 8'h5A, "R9 coincident frame", word_o, 8'h5A);

    wn(10);
    chk(word_o == 8'h5A && word_valid_o == 1'b0, "R10 idle hold", word_o, 8'h5A);
    finish_run();
  end
endmodule